// File: doc/BRIEF.md
# Power-Gating Shutdown Sequencer

This block steps one switchable power domain down into shutdown and back up again. A single-cycle sleep request starts the entry sequence. The domain outputs are isolated first. Next the retention registers are told to save their state. Last, the power gate is opened. A wake request reverses the process in a fixed order:

1. The power gate is closed again.
2. The header switch segments are enabled one after another, from a daisy chain, to limit rush current.
3. A power-good flag rises after a settling delay.
4. The domain is held in reset while retained state is restored.
5. Reset is released, and only then is isolation removed.

An 8-bit data path from the gated domain into the always-on side passes through a clamp inside the block. The clamp forces all zeros whenever isolation is active, so undefined values from an unpowered domain never reach the always-on side. A two-bit status output tells the rest of the chip whether the domain is on, entering shutdown, off, or waking. Signals going into the gated domain need no treatment here.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the block reports the following:
  - status_o = 2'b00 (on).
  - iso_n_o, ret_n_o and dom_rst_no are all 1.
  - pg_en_o is 0.
  - All SEG_NUM switch enables are 1.
  - pwr_good_o is 1.
- R2: When sleep_req_i is sampled high in the on state, the entry sequence runs on consecutive clock edges:
  - First edge: iso_n_o falls and status_o becomes 2'b01 (entering).
  - Second edge: ret_n_o falls.
  - Third edge: pg_en_o rises and status_o becomes 2'b10 (off).
- R3: aon_data_o equals dom_data_i while iso_n_o is 1, and is 8'h00 while iso_n_o is 0.
- R4: On the edge where pg_en_o rises, every switch enable and pwr_good_o drop to 0 together.
- R5: On the edge where pg_en_o falls, status_o becomes 2'b11 (waking). After that the switch enables turn on from bit 0 upward in thermometer order, with segment i turning on (i+1)*SEG_GAP cycles after pg_en_o fell. At most one enable changes per edge.
- R6: pwr_good_o rises WAKE_DLY cycles after the last switch enable turns on.
- R7: The wake tail runs on consecutive edges after the edge where pwr_good_o rises:
  - First edge: dom_rst_no falls.
  - Second edge: ret_n_o rises (restore).
  - Third edge: dom_rst_no rises.
  - Fourth edge: iso_n_o rises and status_o returns to 2'b00.

  ret_n_o stays 0 from the save edge until the restore edge.
- R8: A wake request sampled during the entry sequence is held. Power-up (pg_en_o falling) then starts on the edge right after the off state is reached.
- R9: A sleep request while off and a wake request while on have no effect. No wake is remembered from the on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Always-on asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to shut the domain down |
| wake_req_i | input | 1 | Request to power the domain up |
| dom_data_i | input | DATA_W | Raw data leaving the gated domain |
| aon_data_o | output | DATA_W | Clamped data into the always-on domain |
| iso_n_o | output | 1 | Isolation enable, active low |
| ret_n_o | output | 1 | Retention save/hold, active low |
| pg_en_o | output | 1 | Power-gate enable, high switches domain off |
| dom_rst_no | output | 1 | Domain reset, active low |
| sw_en_o | output | SEG_NUM | Header switch segment enables, daisy-chained |
| pwr_good_o | output | 1 | Domain supply settled |
| status_o | output | 2 | 00 on, 01 entering, 10 off, 11 waking |

## Verification
The interesting collision is a wake request landing while the entry sequence is still running. The wake has to be remembered, and the same sequencer has to finish isolating, saving and gating before it acts on that wake. The bench provokes this by pulsing the wake request in the cycle after the sleep request, while isolation has just been asserted. It then judges the result cycle by cycle: the off state must be reached normally, last exactly one cycle, and be followed at once by the full staggered power-up. A companion scenario checks the opposite case. A wake pulse given while the domain is on must leave nothing pending, so a later shutdown stays off.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PS_ON       = 2'b00,
    PS_ENTERING = 2'b01,
    PS_OFF      = 2'b10,
    PS_WAKING   = 2'b11
  } pwr_status_e;

  typedef enum logic [3:0] {
    ST_ON,
    ST_ISO,
    ST_SAVE,
    ST_OFF,
    ST_PWRUP,
    ST_RST,
    ST_RESTORE,
    ST_RELRST
  } seq_st_e;

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sleep_req_i,
  input  logic        wake_req_i,
  input  logic        pwr_good_i,
  output logic        iso_n_o,
  output logic        ret_n_o,
  output logic        pg_en_o,
  output logic        dom_rst_no,
  output logic        chain_clr_o,
  output logic        chain_run_o,
  output pwr_status_e status_o
);

  seq_st_e state_q, state_d;
  logic    pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    pend_d  = 1'b0;
    unique case (state_q)
      ST_ON:      if (sleep_req_i) state_d = ST_ISO;
      ST_ISO: begin
        state_d = ST_SAVE;
        pend_d  = pend_q | wake_req_i;
      end
      ST_SAVE: begin
        state_d = ST_OFF;
        pend_d  = pend_q | wake_req_i;
      end
      ST_OFF:     if (wake_req_i || pend_q) state_d = ST_PWRUP;
      ST_PWRUP:   if (pwr_good_i) state_d = ST_RST;
      ST_RST:     state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_RELRST;
      ST_RELRST:  state_d = ST_ON;
      default:    state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    iso_n_o    = (state_q == ST_ON);
    ret_n_o    = (state_q == ST_ON) || (state_q == ST_ISO) ||
                 (state_q == ST_RESTORE) || (state_q == ST_RELRST);
    pg_en_o    = (state_q == ST_OFF);
    dom_rst_no = !((state_q == ST_RST) || (state_q == ST_RESTORE));
    unique case (state_q)
      ST_ON:           status_o = PS_ON;
      ST_ISO, ST_SAVE: status_o = PS_ENTERING;
      ST_OFF:          status_o = PS_OFF;
      default:         status_o = PS_WAKING;
    endcase
  end

  // switches cleared on the same edge the gate opens; counting resumes once out of off
  assign chain_clr_o = (state_d == ST_OFF);
  assign chain_run_o = (state_q != ST_OFF);

  p_pg_isolated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_o |-> (!iso_n_o && !ret_n_o));

  p_save_before_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_en_o) |-> !$past(ret_n_o));

  p_rst_after_good_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dom_rst_no) |-> $past(pwr_good_i));

  p_restore_in_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ret_n_o) |-> !dom_rst_no);

  p_deiso_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_n_o) |-> (dom_rst_no && $past(dom_rst_no) && ret_n_o && !pg_en_o));

  p_pend_service_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && pend_q) |=> (state_q == ST_PWRUP));

  p_off_sleep_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && !wake_req_i && !pend_q) |=> (state_q == ST_OFF));

endmodule

// File: rtl/pwr_sw_chain.sv
module pwr_sw_chain #(
  parameter int SEG_NUM  = 8,
  parameter int SEG_GAP  = 4,
  parameter int WAKE_DLY = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               run_i,
  output logic [SEG_NUM-1:0] sw_en_o,
  output logic               pwr_good_o
);

  localparam int CNT_MAX = (SEG_GAP > WAKE_DLY) ? SEG_GAP : WAKE_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(SEG_GAP - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_DLY - 1);

  logic [SEG_NUM-1:0] sw_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               good_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= '1;
      cnt_q  <= '0;
      good_q <= 1'b1;
    end else if (clr_i) begin
      sw_q   <= '0;
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (run_i && !good_q) begin
      if (!sw_q[SEG_NUM-1]) begin
        if (cnt_q == GAP_LAST) begin
          sw_q  <= {sw_q[SEG_NUM-2:0], 1'b1};
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        // reuse the gap counter for the settling delay
        if (cnt_q == WAKE_LAST) begin
          good_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sw_en_o    = sw_q;
  assign pwr_good_o = good_q;

  p_one_seg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($countones(sw_q ^ $past(sw_q)) <= 1));

  p_thermo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_q & (sw_q + 1'b1)) == '0));

  p_good_needs_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_q |-> (&sw_q));

  p_clr_all_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sw_q == '0 && !good_q));

endmodule

// File: rtl/pwr_iso_clamp.sv
module pwr_iso_clamp #(
  parameter int DATA_W = 8
) (
  input  logic              iso_n_i,
  input  logic [DATA_W-1:0] dom_data_i,
  output logic [DATA_W-1:0] aon_data_o
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign aon_data_o[b] = dom_data_i[b] & iso_n_i;
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEG_NUM  = 8,
  parameter int SEG_GAP  = 4,
  parameter int WAKE_DLY = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic               wake_req_i,
  input  logic [DATA_W-1:0]  dom_data_i,
  output logic [DATA_W-1:0]  aon_data_o,
  output logic               iso_n_o,
  output logic               ret_n_o,
  output logic               pg_en_o,
  output logic               dom_rst_no,
  output logic [SEG_NUM-1:0] sw_en_o,
  output logic               pwr_good_o,
  output logic [1:0]         status_o
);

  logic        chain_clr, chain_run, good;
  pwr_status_e status;

  pwr_seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .wake_req_i  (wake_req_i),
    .pwr_good_i  (good),
    .iso_n_o     (iso_n_o),
    .ret_n_o     (ret_n_o),
    .pg_en_o     (pg_en_o),
    .dom_rst_no  (dom_rst_no),
    .chain_clr_o (chain_clr),
    .chain_run_o (chain_run),
    .status_o    (status)
  );

  pwr_sw_chain #(
    .SEG_NUM  (SEG_NUM),
    .SEG_GAP  (SEG_GAP),
    .WAKE_DLY (WAKE_DLY)
  ) i_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (chain_clr),
    .run_i      (chain_run),
    .sw_en_o    (sw_en_o),
    .pwr_good_o (good)
  );

  pwr_iso_clamp #(.DATA_W(DATA_W)) i_clamp (
    .iso_n_i    (iso_n_o),
    .dom_data_i (dom_data_i),
    .aon_data_o (aon_data_o)
  );

  assign pwr_good_o = good;
  assign status_o   = status;

  p_clamp_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_n_o |-> (aon_data_o == '0));

  p_gate_drops_switches_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_o |-> (sw_en_o == '0 && !pwr_good_o));

  p_on_fully_powered_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == PS_ON) |-> (pwr_good_o && (&sw_en_o) && iso_n_o && ret_n_o && dom_rst_no));

endmodule

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;

  localparam int N  = 8;
  localparam int G  = 4;
  localparam int W  = 6;
  localparam int GD = N * G + W;   // cycles from gate close to power good

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sleep_req = 1'b0;
  logic         wake_req = 1'b0;
  logic [7:0]   dom_data = 8'h00;
  logic [7:0]   aon_data;
  logic         iso_n, ret_n, pg_en, dom_rst_n, pwr_good;
  logic [N-1:0] sw_en;
  logic [1:0]   status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sleep_req_i (sleep_req),
    .wake_req_i  (wake_req),
    .dom_data_i  (dom_data),
    .aon_data_o  (aon_data),
    .iso_n_o     (iso_n),
    .ret_n_o     (ret_n),
    .pg_en_o     (pg_en),
    .dom_rst_no  (dom_rst_n),
    .sw_en_o     (sw_en),
    .pwr_good_o  (pwr_good),
    .status_o    (status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_ctrl(input string tag, input int e_iso, input int e_ret, input int e_pg,
                          input int e_rst, input int e_sw, input int e_good, input int e_st);
    chk({tag, " iso_n"},  int'(iso_n),     e_iso);
    chk({tag, " ret_n"},  int'(ret_n),     e_ret);
    chk({tag, " pg_en"},  int'(pg_en),     e_pg);
    chk({tag, " rst_n"},  int'(dom_rst_n), e_rst);
    chk({tag, " sw_en"},  int'(sw_en),     e_sw);
    chk({tag, " good"},   int'(pwr_good),  e_good);
    chk({tag, " status"}, int'(status),    e_st);
  endtask

  // R1 reset state, R3 pass-through while on
  task automatic t_reset;
    @(negedge clk);
    chk_ctrl("R1 reset", 1, 1, 0, 1, 8'hFF, 1, 0);
    dom_data = 8'h3C;
    #1 chk("R3 pass 3C", int'(aon_data), 8'h3C);
    dom_data = 8'hC3;
    #1 chk("R3 pass C3", int'(aon_data), 8'hC3);
  endtask

  // R2 entry order, R3 clamp, R4 switches drop with gate; ends just after off reached
  task automatic t_enter(input logic [7:0] pat, input bit wake_mid);
    @(negedge clk);
    dom_data  = pat;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    wake_req  = wake_mid;
    chk_ctrl("R2 iso step", 0, 1, 0, 1, 8'hFF, 1, 1);
    chk("R3 clamp", int'(aon_data), 0);
    @(negedge clk);
    wake_req = 1'b0;
    chk_ctrl("R2 save step", 0, 0, 0, 1, 8'hFF, 1, 1);
    @(negedge clk);
    chk_ctrl("R4 off step", 0, 0, 1, 1, 0, 0, 2);
    chk("R3 clamp off", int'(aon_data), 0);
  endtask

  // R5/R6/R7: cycle c=0 is the first sample after pg_en falls
  task automatic t_wake_run(input string tag);
    for (int c = 0; c <= GD + 4; c++) begin
      int segs, e_sw, e_good, e_iso, e_ret, e_rst, e_st;
      segs   = (c / G > N) ? N : c / G;
      e_sw   = (1 << segs) - 1;
      e_good = (c >= GD) ? 1 : 0;
      e_iso  = (c == GD + 4) ? 1 : 0;
      e_ret  = (c >= GD + 2) ? 1 : 0;
      e_rst  = (c == GD + 1 || c == GD + 2) ? 0 : 1;
      e_st   = (c == GD + 4) ? 0 : 3;
      if (c < GD) chk_ctrl({tag, " R5 ramp"}, e_iso, e_ret, 0, e_rst, e_sw, e_good, e_st);
      else if (c == GD) chk_ctrl({tag, " R6 good"}, e_iso, e_ret, 0, e_rst, e_sw, e_good, e_st);
      else chk_ctrl({tag, " R7 tail"}, e_iso, e_ret, 0, e_rst, e_sw, e_good, e_st);
      if (c == GD + 4) chk({tag, " R3 pass"}, int'(aon_data), int'(dom_data));
      @(negedge clk);
    end
  endtask

  task automatic t_sleep_wake;
    t_enter(8'hA5, 1'b0);
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    t_wake_run("normal");
  endtask

  // R8 wake during entry held, serviced the edge after off
  task automatic t_wake_pending;
    t_enter(8'h5A, 1'b1);
    @(negedge clk);
    chk("R8 pending serviced pg_en", int'(pg_en), 0);
    t_wake_run("R8 pending");
  endtask

  // R9 sleep while off ignored, wake while on not remembered
  task automatic t_ignored;
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk_ctrl("R9 wake in on", 1, 1, 0, 1, 8'hFF, 1, 0);
      @(negedge clk);
    end
    t_enter(8'hFF, 1'b0);
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk_ctrl("R9 stays off", 0, 0, 1, 1, 0, 0, 2);
      @(negedge clk);
    end
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    t_wake_run("R9 recover");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sleep_wake();
    t_wake_pending();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule